// File: doc/BRIEF.md
# Modem Status Change Tracker

This block watches four active-low modem handshake inputs (clear to send, data set ready, ring, carrier) and turns them into an 8-bit status word. The high nibble shows whether each line is asserted right now. The low nibble holds change flags that stay set until the host reads the status. The block also holds a small control register. That register drives four active-low modem outputs (terminal ready, request to send and two auxiliary lines) and selects a diagnostic loopback mode.

Each input pin passes through a synchronizer and then a line-state register. Change detection compares the next line state with the registered one, so all four flags are updated on the same clock edge as the state bits. The host reads the status by pulsing `stat_rd`. The word it sees during the strobe cycle is the word being consumed. The flags are cleared on the edge that ends the strobe. An edge that lands on that same clock edge is not lost: it stays recorded for the next read.

In loopback the external input pins are ignored and the line states come from the control register instead. The external output pins are forced to their idle (high) level. There is no streaming data path; every pin is a plain level or strobe.

Top module: `modem_stat_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, `stat_q` is 0x00, `ctrl_q` is 0x00 and all four output pins (`term_ready_n`, `req_send_n`, `aux1_n`, `aux2_n`) are high.
- R2: `stat_q` bits 7, 6, 5 and 4 are 1 when, respectively, `carrier_n`, `ring_n`, `set_ready_n` and `clr_send_n` are low. A pin change becomes visible on the third rising clock edge after it, and not before.
- R3: `stat_q` bits 3 (carrier), 1 (data set ready) and 0 (clear to send) are set whenever the matching line state changes in either direction.
- R4: `stat_q` bit 2 is set only when the ring line goes from asserted to deasserted (pin low to high). A ring pin going low sets no flag.
- R5: A set change flag stays set through any further line activity until a status read, and repeated changes still read as a single 1.
- R6: While `stat_rd` is high, `stat_q` shows the flags still set. On the clock edge that samples `stat_rd` high, every flag with no new change on that edge is cleared.
- R7: A line change that updates the line state on the same edge that samples `stat_rd` high leaves its flag set after the read.
- R8: A write (`ctrl_we` high) stores `ctrl_wdata`. With loopback off, control bits 0, 1, 2 and 3 set to 1 drive `term_ready_n`, `req_send_n`, `aux1_n` and `aux2_n` low respectively; a 0 drives the pin high. The pins follow on the edge after the write.
- R9: `ctrl_q` returns control bits 4 to 0 as written; bits 7 to 5 always read 0.
- R10: With control bit 4 set (loopback), the external input pins have no effect. The line states become: clear to send = control bit 1, data set ready = control bit 0, ring = control bit 2, carrier = control bit 3. They appear on the second edge after the write. Change flags follow R3 and R4.
- R11: While control bit 4 is set, all four output pins are held high whatever bits 3 to 0 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_q | output | 8 | Control register read value (bits 7:5 zero) |
| stat_rd | input | 1 | Status read strobe; clears change flags |
| stat_q | output | 8 | Status word: line states high nibble, change flags low nibble |
| clr_send_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| set_ready_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ring_n | input | 1 | Ring pin, active low, asynchronous |
| carrier_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| term_ready_n | output | 1 | Terminal-ready pin, active low |
| req_send_n | output | 1 | Request-to-send pin, active low |
| aux1_n | output | 1 | Auxiliary output 1, active low |
| aux2_n | output | 1 | Auxiliary output 2, active low |

## Verification
The bench drives the ring pin in both directions, because a tracker that flags the leading edge (or both edges) of ring would raise bit 2 when the line asserts. It schedules a pin change to land on the exact edge of a read strobe: a design that clears unconditionally would lose that event. The same read also clears a different, older flag, so a design that ignored the read would be caught. Loopback is stepped through each control bit in turn while the external pins are driven opposite. A swapped route (for example terminal ready landing on clear to send) shows up as the wrong high-nibble bit, and a leak from the external pins shows up as flags changing. The bench also checks the pin-visibility latency one edge early, so a missing synchronizer stage is reported.

// File: rtl/msct_pkg.sv
package msct_pkg;

  localparam int unsigned LINE_CNT  = 4;
  localparam int unsigned STAT_W    = 2 * LINE_CNT;
  localparam int unsigned CTRL_W    = 8;

  // line index = bit position in both status nibbles
  localparam int unsigned LN_CTS    = 0;
  localparam int unsigned LN_DSR    = 1;
  localparam int unsigned LN_RING   = 2;
  localparam int unsigned LN_CARR   = 3;

  // control bit positions
  localparam int unsigned CB_TERM   = 0;
  localparam int unsigned CB_REQ    = 1;
  localparam int unsigned CB_AUX1   = 2;
  localparam int unsigned CB_AUX2   = 3;
  localparam int unsigned CB_LOOP   = 4;
  localparam int unsigned CTRL_USED = 5;

  typedef enum logic [0:0] {
    EDGE_ANY  = 1'b0,   // flag on every change
    EDGE_FALL = 1'b1    // flag only when the line deasserts
  } edge_kind_e;

  // active-high line values produced by loopback from control bits
  function automatic logic [LINE_CNT-1:0] loop_route(input logic [CTRL_W-1:0] c);
    logic [LINE_CNT-1:0] r;
    r[LN_CTS]  = c[CB_REQ];
    r[LN_DSR]  = c[CB_TERM];
    r[LN_RING] = c[CB_AUX1];
    r[LN_CARR] = c[CB_AUX2];
    return r;
  endfunction

endpackage

// File: rtl/msct_sync.sv
module msct_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [WIDTH-1:0] chain_q [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= {WIDTH{RST_VAL}};
          else        chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= {WIDTH{RST_VAL}};
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[DEPTH-1];

endmodule

// File: rtl/msct_delta.sv
module msct_delta
  import msct_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_prev_i,
  input  logic line_next_i,
  input  logic clear_i,
  output logic flag_o
);

  logic evt;
  logic flag_q;

  generate
    if (KIND == EDGE_FALL) begin : g_fall
      assign evt = line_prev_i & ~line_next_i;
    end else begin : g_any
      assign evt = line_prev_i ^ line_next_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (clear_i) flag_q <= evt;
    else              flag_q <= flag_q | evt;
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clear_i) |=> flag_q); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && (line_prev_i == line_next_i)) |=> !flag_q); // R6

  AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && line_prev_i && !line_next_i) |=> flag_q); // R7

  generate
    if (KIND == EDGE_FALL) begin : g_lead_chk
      AST_LEAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !line_prev_i && line_next_i) |=> !flag_q); // R4
    end
  endgenerate

endmodule

// File: rtl/msct_ctrl.sv
module msct_ctrl
  import msct_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [CTRL_W-1:0]   wdata_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                loop_o,
  output logic [LINE_CNT-1:0] route_o,
  output logic [3:0]          pins_n_o   // {aux2, aux1, req, term}
);

  logic [CTRL_USED-1:0] reg_q;
  logic [CTRL_W-1:0]    full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    reg_q <= '0;
    else if (we_i) reg_q <= wdata_i[CTRL_USED-1:0];
  end

  assign full    = {{(CTRL_W-CTRL_USED){1'b0}}, reg_q};
  assign ctrl_o  = full;
  assign loop_o  = reg_q[CB_LOOP];
  assign route_o = loop_route(full);

  generate
    for (genvar b = 0; b < 4; b++) begin : g_pin
      assign pins_n_o[b] = reg_q[CB_LOOP] | ~reg_q[b];
    end
  endgenerate

  AST_TERM_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !wdata_i[CB_LOOP] && wdata_i[CB_TERM]) |=> !pins_n_o[CB_TERM]); // R8

  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wdata_i[CB_LOOP]) |=> (pins_n_o == 4'hF)); // R11

endmodule

// File: rtl/modem_stat_tracker.sv
module modem_stat_tracker
  import msct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [7:0]  ctrl_wdata,
  output logic [7:0]  ctrl_q,
  input  logic        stat_rd,
  output logic [7:0]  stat_q,
  input  logic        clr_send_n,
  input  logic        set_ready_n,
  input  logic        ring_n,
  input  logic        carrier_n,
  output logic        term_ready_n,
  output logic        req_send_n,
  output logic        aux1_n,
  output logic        aux2_n
);

  logic [LINE_CNT-1:0] pins_raw;
  logic [LINE_CNT-1:0] pins_sync;
  logic [LINE_CNT-1:0] line_next;
  logic [LINE_CNT-1:0] line_q;
  logic [LINE_CNT-1:0] flags;
  logic [LINE_CNT-1:0] route;
  logic [3:0]          out_n;
  logic                loop_en;

  assign pins_raw[LN_CTS]  = clr_send_n;
  assign pins_raw[LN_DSR]  = set_ready_n;
  assign pins_raw[LN_RING] = ring_n;
  assign pins_raw[LN_CARR] = carrier_n;

  msct_sync #(
    .WIDTH   (LINE_CNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_raw),
    .sync_o  (pins_sync)
  );

  msct_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (ctrl_we),
    .wdata_i  (ctrl_wdata),
    .ctrl_o   (ctrl_q),
    .loop_o   (loop_en),
    .route_o  (route),
    .pins_n_o (out_n)
  );

  assign line_next = loop_en ? route : ~pins_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_next;
  end

  generate
    for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
      localparam edge_kind_e KIND_I = (i == LN_RING) ? EDGE_FALL : EDGE_ANY;
      msct_delta #(.KIND(KIND_I)) u_delta (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_prev_i (line_q[i]),
        .line_next_i (line_next[i]),
        .clear_i     (stat_rd),
        .flag_o      (flags[i])
      );
      if (i != LN_RING) begin : g_any_chk
        AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
          (stat_q[LINE_CNT+i] != $past(stat_q[LINE_CNT+i])) |-> stat_q[i]); // R3
      end
    end
  endgenerate

  assign stat_q = {line_q, flags};

  assign term_ready_n = out_n[CB_TERM];
  assign req_send_n   = out_n[CB_REQ];
  assign aux1_n       = out_n[CB_AUX1];
  assign aux2_n       = out_n[CB_AUX2];

  AST_RING_TRAIL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_q[LINE_CNT+LN_RING]) && !stat_q[LINE_CNT+LN_RING]) |-> stat_q[LN_RING]); // R4

  AST_LOOP_FOLLOWS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_q[CB_LOOP]) && ctrl_q[CB_LOOP]) |-> (stat_q[LINE_CNT+LN_CTS] == $past(ctrl_q[CB_REQ]))); // R10

endmodule

// File: tb/modem_stat_tracker_test.sv
`timescale 1ns/1ps
module modem_stat_tracker_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_we;
  logic [7:0] ctrl_wdata;
  logic [7:0] ctrl_q;
  logic       stat_rd;
  logic [7:0] stat_q;
  logic       clr_send_n, set_ready_n, ring_n, carrier_n;
  logic       term_ready_n, req_send_n, aux1_n, aux2_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  modem_stat_tracker uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .ctrl_q       (ctrl_q),
    .stat_rd      (stat_rd),
    .stat_q       (stat_q),
    .clr_send_n   (clr_send_n),
    .set_ready_n  (set_ready_n),
    .ring_n       (ring_n),
    .carrier_n    (carrier_n),
    .term_ready_n (term_ready_n),
    .req_send_n   (req_send_n),
    .aux1_n       (aux1_n),
    .aux2_n       (aux2_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pins();
    return {4'h0, aux2_n, aux1_n, req_send_n, term_ready_n};
  endfunction

  task automatic do_read(output logic [7:0] seen);
    stat_rd = 1'b1;
    #0.1 seen = stat_q;
    tick(1);
    stat_rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    tick(1);
    ctrl_we = 1'b0;
  endtask

  task automatic t_reset();
    check8("R1 status", stat_q, 8'h00);
    check8("R1 control", ctrl_q, 8'h00);
    check8("R1 pins", pins(), 8'h0F);
  endtask

  task automatic t_cts();
    logic [7:0] s;
    clr_send_n = 1'b0;
    tick(2);
    check8("R2 latency early", stat_q, 8'h00);
    tick(1);
    check8("R2/R3 cts assert", stat_q, 8'h11);
    do_read(s);
    check8("R6 read shows flags", s, 8'h11);
    check8("R6 cleared after read", stat_q, 8'h10);
    clr_send_n = 1'b1;
    tick(3);
    check8("R3 cts release", stat_q, 8'h01);
    do_read(s);
    check8("R6 cleared", stat_q, 8'h00);
  endtask

  task automatic t_dsr_carrier();
    logic [7:0] s;
    set_ready_n = 1'b0; carrier_n = 1'b0;
    tick(3);
    check8("R2/R3 dsr+carrier assert", stat_q, 8'hAA);
    do_read(s);
    check8("R6 dsr+carrier read", stat_q, 8'hA0);
    set_ready_n = 1'b1; carrier_n = 1'b1;
    tick(3);
    check8("R3 dsr+carrier release", stat_q, 8'h0A);
    do_read(s);
    check8("R6 cleared", stat_q, 8'h00);
  endtask

  task automatic t_ring();
    logic [7:0] s;
    ring_n = 1'b0;
    tick(3);
    check8("R4 ring lead no flag", stat_q, 8'h40);
    ring_n = 1'b1;
    tick(3);
    check8("R4 ring trail flag", stat_q, 8'h04);
    do_read(s);
    check8("R4 ring cleared", stat_q, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] s;
    clr_send_n = 1'b0;
    tick(5);
    clr_send_n = 1'b1;
    tick(5);
    clr_send_n = 1'b0;
    tick(5);
    clr_send_n = 1'b1;
    tick(10);
    check8("R5 sticky after toggles", stat_q, 8'h01);
    do_read(s);
    check8("R5 single read clears", stat_q, 8'h00);
  endtask

  task automatic t_same_edge();
    logic [7:0] s;
    set_ready_n = 1'b0;
    tick(3);
    check8("R3 dsr set", stat_q, 8'h22);
    clr_send_n = 1'b0;
    tick(2);
    do_read(s);
    check8("R6 read value before event", s, 8'h22);
    check8("R7 event on read edge kept", stat_q, 8'h31);
    do_read(s);
    set_ready_n = 1'b1; clr_send_n = 1'b1;
    tick(4);
    do_read(s);
    check8("R7 cleanup", stat_q, 8'h00);
  endtask

  task automatic t_ctrl();
    do_write(8'h03);
    check8("R8 term/req low", pins(), 8'h0C);
    check8("R9 readback", ctrl_q, 8'h03);
    do_write(8'h0C);
    check8("R8 aux low", pins(), 8'h03);
    do_write(8'hEF);
    check8("R9 reserved zero", ctrl_q, 8'h0F);
    check8("R8 all low", pins(), 8'h00);
    do_write(8'hFF);
    check8("R9 reserved zero loop", ctrl_q, 8'h1F);
    check8("R11 loop pins idle", pins(), 8'h0F);
    do_write(8'h00);
    tick(2);
  endtask

  task automatic t_loop();
    logic [7:0] s;
    clr_send_n = 1'b0; set_ready_n = 1'b0; ring_n = 1'b0; carrier_n = 1'b0;
    tick(4);
    do_read(s);
    check8("R2 all asserted", stat_q, 8'hF0);
    do_write(8'h10);
    tick(1);
    check8("R10 loop all off", stat_q, 8'h0F);
    clr_send_n = 1'b1; set_ready_n = 1'b1; ring_n = 1'b1; carrier_n = 1'b1;
    tick(5);
    check8("R10 external ignored", stat_q, 8'h0F);
    do_read(s);
    do_write(8'h12);
    tick(1);
    check8("R10 req->cts", stat_q, 8'h11);
    check8("R11 pins idle", pins(), 8'h0F);
    do_read(s);
    do_write(8'h14);
    tick(1);
    check8("R10 aux1->ring", stat_q, 8'h41);
    do_read(s);
    do_write(8'h18);
    tick(1);
    check8("R10 aux2->carrier", stat_q, 8'h8C);
    do_read(s);
    do_write(8'h11);
    tick(1);
    check8("R10 term->dsr", stat_q, 8'h2A);
    check8("R11 pins idle term", pins(), 8'h0F);
    do_write(8'h00);
    tick(1);
    do_read(s);
    check8("R10 leave loop", stat_q, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; stat_rd = 1'b0;
    clr_send_n = 1'b1; set_ready_n = 1'b1; ring_n = 1'b1; carrier_n = 1'b1;
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_cts();
    t_dsr_carrier();
    t_ring();
    t_sticky();
    t_same_edge();
    t_ctrl();
    t_loop();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule